// File: doc/BRIEF.md
# I2C Master Start and Bus-Recovery Controller

This block decides when an I2C master may put a START on the bus and how it gets the bus back when something goes wrong. Software raises a start request and a stop request and clears an interrupt flag. The block reports its progress through an 8-bit status code and that flag. It watches the SDA and SCL lines through two-flop synchronizers. From them it derives START and STOP events and a bus-busy indication.

Arbitration loss is detected on a rising SCL edge where the master wants SDA high but sees it low. If the start request is still held, the block re-enters the queue and issues a fresh START by itself once the bus is free. A START raised by another master while no repeated START of its own is pending makes the block quietly let go of the bus and retry after the next STOP. An unexpected STOP while mastering, or any START or STOP while addressed as a slave, is a bus error. A bus that stays busy with SCL parked high is taken over after a programmable number of idle cycles.

Byte shifting, acknowledge handling and slave decoding live outside this block. Their results appear here as plain inputs: the bit to be driven, the kind of transfer in progress, whether a repeated START is pending, and whether the device is addressed.

Top module: `i2c_arb_recover`

## Requirements
- R1: After reset the status code is 0xF8, the interrupt flag is 0, the block is not master and the bus is reported free. At every later point the flag is 1 exactly when the status code differs from 0xF8.
- R2: With the start request held and the bus free, the block takes mastership, reports 0x08 and sets the interrupt flag.
- R3: A START seen on the synchronized lines (SDA falling while SCL stays high) marks the bus busy. A STOP (SDA rising while SCL stays high) marks it free.
- R4: While master, an SCL rising edge with the drive bit at 1 and SDA sampled at 0 is a lost arbitration. Mastership is dropped, the flag is set and the status takes the code for the transfer kind input: 0 gives 0x38, 1 gives 0x68, 2 gives 0x78, 3 gives 0xB0.
- R5: If the start request is still held after a lost arbitration, the block issues a new START (0x08) as soon as the bus becomes free, with no flag clear in between.
- R6: A START from the bus while master, with no own repeated START pending, releases mastership without touching the flag or the status. With the start request held, a START (0x08) follows the next STOP.
- R7: A START from the bus while master with the own repeated-START input high reports 0x10, sets the flag and keeps mastership.
- R8: A STOP while master with no stop request pending, or a START or STOP while idle with the slave-addressed input high, reports 0x00, sets the flag, drops mastership and clears a pending stop request.
- R9: A pending stop request while master ends mastership and marks the bus free. The stop request reads back as 1 while pending and returns to 0 once it has been served.
- R10: A flag-clear pulse clears the interrupt flag and returns the status to 0xF8.
- R11: With the start request held on a busy bus, once SCL has stayed high for the programmed idle count, the block forces a START (0x08). It does not do so while the count is not yet reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_drive_i | input | 1 | Bit the byte engine currently drives on SDA |
| sta_i | input | 1 | Start request, level |
| sto_set_i | input | 1 | Stop request, one-cycle pulse |
| si_clr_i | input | 1 | Interrupt flag clear, one-cycle pulse |
| rs_own_i | input | 1 | Own repeated START is being raised |
| slv_addr_i | input | 1 | Device is addressed as a slave |
| lost_kind_i | input | 2 | Transfer kind, selects the lost-arbitration code |
| idle_limit_i | input | CNT_W | SCL-idle cycles before a forced access |
| status_o | output | 8 | Status code |
| si_o | output | 1 | Interrupt flag |
| sto_o | output | 1 | Stop request pending |
| master_o | output | 1 | Block holds mastership |
| busy_o | output | 1 | Bus busy |

## Verification
The bench builds the block with CNT_W set to 8 and drives an idle limit of 20. This brings the forced-access takeover within a few dozen cycles, so the bench can probe it both before and after the count is reached. The two-stage synchronizer default is kept, so every line change reaches the control logic three edges later. Each bus step is given enough settling time for the status sequence to be compared in order. The four lost-arbitration codes are all reached by stepping the transfer-kind input across separate lost transfers.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_MST  = 2'd2
  } ctl_st_e;

  localparam logic [7:0] CODE_NONE   = 8'hF8;
  localparam logic [7:0] CODE_START  = 8'h08;
  localparam logic [7:0] CODE_RSTART = 8'h10;
  localparam logic [7:0] CODE_BUSERR = 8'h00;

  function automatic logic [7:0] lost_code(input logic [1:0] kind);
    case (kind)
      2'd0:    return 8'h38;
      2'd1:    return 8'h68;
      2'd2:    return 8'h78;
      default: return 8'hB0;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_i,
  input  logic scl_i,
  input  logic own_start,
  input  logic clr_busy,
  output logic sda_s,
  output logic scl_s,
  output logic scl_p,
  output logic scl_rise,
  output logic start_det,
  output logic stop_det,
  output logic busy
);
  logic [SYNC_STAGES-1:0] sda_sh, scl_sh;
  logic sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_sh <= '1;
      scl_sh <= '1;
      sda_p  <= 1'b1;
      scl_p  <= 1'b1;
    end else begin
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_p  <= sda_s;
      scl_p  <= scl_s;
    end
  end

  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     busy <= 1'b0;
    else if (start_det || own_start) busy <= 1'b1;
    else if (stop_det || clr_busy)   busy <= 1'b0;
  end
endmodule

// File: rtl/i2c_force_timer.sv
module i2c_force_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             scl_s,
  input  logic             scl_p,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] cnt;
  logic             idle;

  function automatic logic expired(input logic [CNT_W-1:0] c,
                                   input logic [CNT_W-1:0] lim);
    return c >= lim;
  endfunction

  assign idle = scl_s & scl_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!en || !idle)    cnt <= '0;
    else if (cnt != {CNT_W{1'b1}}) cnt <= cnt + 1'b1;
  end

  assign hit = en & idle & expired(cnt, limit);
endmodule

// File: rtl/i2c_start_ctl.sv
module i2c_start_ctl
  import i2c_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sta_i,
  input  logic       sto_set_i,
  input  logic       si_clr_i,
  input  logic       rs_own_i,
  input  logic       slv_addr_i,
  input  logic [1:0] lost_kind_i,
  input  logic       sda_drive_i,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       busy,
  input  logic       force_hit,
  output logic       own_start,
  output logic       clr_busy,
  output logic       arb_lost,
  output logic       bus_err,
  output logic       waiting,
  output logic       master,
  output logic [7:0] status,
  output logic       si,
  output logic       sto
);
  ctl_st_e    st, st_n;
  logic [7:0] code_n;
  logic       si_n, sto_n, go;

  always_comb begin
    st_n      = st;
    code_n    = status;
    si_n      = si;
    sto_n     = sto | sto_set_i;
    own_start = 1'b0;
    clr_busy  = 1'b0;
    arb_lost  = 1'b0;
    bus_err   = 1'b0;
    go        = 1'b0;
    if (si_clr_i) begin
      si_n   = 1'b0;
      code_n = CODE_NONE;
    end
    case (st)
      ST_IDLE: begin
        if (slv_addr_i && (start_det || stop_det)) bus_err = 1'b1;
        else if (sta_i && !busy)                   go = 1'b1;
        else if (sta_i)                            st_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (!sta_i)                  st_n = ST_IDLE;
        else if (force_hit || !busy) go = 1'b1;
      end
      ST_MST: begin
        if (sto) begin
          clr_busy = 1'b1;
          sto_n    = 1'b0;
          st_n     = ST_IDLE;
        end else if (stop_det) begin
          bus_err = 1'b1;
        end else if (start_det) begin
          if (rs_own_i) begin
            code_n = CODE_RSTART;
            si_n   = 1'b1;
          end else begin
            st_n = sta_i ? ST_WAIT : ST_IDLE;
          end
        end else if (scl_rise && sda_drive_i && !sda_s) begin
          arb_lost = 1'b1;
          code_n   = lost_code(lost_kind_i);
          si_n     = 1'b1;
          st_n     = sta_i ? ST_WAIT : ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (go) begin
      own_start = 1'b1;
      st_n      = ST_MST;
      code_n    = CODE_START;
      si_n      = 1'b1;
    end
    if (bus_err) begin
      st_n   = ST_IDLE;
      code_n = CODE_BUSERR;
      si_n   = 1'b1;
      sto_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      status <= CODE_NONE;
      si     <= 1'b0;
      sto    <= 1'b0;
    end else begin
      st     <= st_n;
      status <= code_n;
      si     <= si_n;
      sto    <= sto_n;
    end
  end

  assign waiting = (st == ST_WAIT);
  assign master  = (st == ST_MST);
endmodule

// File: rtl/i2c_arb_recover.sv
module i2c_arb_recover #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             sda_drive_i,
  input  logic             sta_i,
  input  logic             sto_set_i,
  input  logic             si_clr_i,
  input  logic             rs_own_i,
  input  logic             slv_addr_i,
  input  logic [1:0]       lost_kind_i,
  input  logic [CNT_W-1:0] idle_limit_i,
  output logic [7:0]       status_o,
  output logic             si_o,
  output logic             sto_o,
  output logic             master_o,
  output logic             busy_o
);
  logic sda_s, scl_s, scl_p, scl_rise;
  logic start_det, stop_det;
  logic own_start, clr_busy, arb_lost, bus_err;
  logic waiting, force_hit, force_en;

  i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_i), .scl_i(scl_i),
    .own_start(own_start), .clr_busy(clr_busy),
    .sda_s(sda_s), .scl_s(scl_s), .scl_p(scl_p), .scl_rise(scl_rise),
    .start_det(start_det), .stop_det(stop_det), .busy(busy_o)
  );

  assign force_en = waiting & busy_o & sta_i;

  i2c_force_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(force_en), .scl_s(scl_s), .scl_p(scl_p),
    .limit(idle_limit_i), .hit(force_hit)
  );

  i2c_start_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .sta_i(sta_i), .sto_set_i(sto_set_i),
    .si_clr_i(si_clr_i), .rs_own_i(rs_own_i), .slv_addr_i(slv_addr_i),
    .lost_kind_i(lost_kind_i), .sda_drive_i(sda_drive_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .start_det(start_det), .stop_det(stop_det),
    .busy(busy_o), .force_hit(force_hit), .own_start(own_start),
    .clr_busy(clr_busy), .arb_lost(arb_lost), .bus_err(bus_err),
    .waiting(waiting), .master(master_o), .status(status_o), .si(si_o),
    .sto(sto_o)
  );
endmodule

// File: rtl/i2c_arb_recover_chk.sv
module i2c_arb_recover_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status,
  input logic       si,
  input logic       sto,
  input logic       master,
  input logic       busy,
  input logic       start_det,
  input logic       stop_det,
  input logic       own_start,
  input logic       arb_lost,
  input logic       bus_err,
  input logic       force_hit
);
  assert_flag_matches_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    si == (status != 8'hF8));

  assert_start_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master) |-> (status == 8'h08) && si);

  assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> busy);

  assert_stop_frees_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !own_start) |=> !busy);

  assert_lost_drops_master_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> !master && si);

  assert_bus_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> (status == 8'h00) && si && !sto && !master);

  assert_forced_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    force_hit |=> master && (status == 8'h08));
endmodule

bind i2c_arb_recover i2c_arb_recover_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status(status_o), .si(si_o), .sto(sto_o),
  .master(master_o), .busy(busy_o), .start_det(start_det),
  .stop_det(stop_det), .own_start(own_start), .arb_lost(arb_lost),
  .bus_err(bus_err), .force_hit(force_hit)
);

// File: tb/i2c_arb_recover_tb.sv
module i2c_arb_recover_tb;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, drv = 1'b1;
  logic sta = 1'b0, sto_set = 1'b0, si_clr = 1'b0, rs_own = 1'b0, slv = 1'b0;
  logic [1:0] kind = 2'd0;
  logic [CNT_W-1:0] limit = 8'd20;
  logic [7:0] status;
  logic si, sto, master, busy;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic [7:0] last_status;

  always #5 clk = ~clk;

  i2c_arb_recover #(.SYNC_STAGES(2), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_drive_i(drv),
    .sta_i(sta), .sto_set_i(sto_set), .si_clr_i(si_clr), .rs_own_i(rs_own),
    .slv_addr_i(slv), .lost_kind_i(kind), .idle_limit_i(limit),
    .status_o(status), .si_o(si), .sto_o(sto), .master_o(master), .busy_o(busy)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_code(input logic [7:0] c);
    exp_q.push_back(c);
  endtask

  // scoreboard monitor: every status change must match the next queued code
  initial begin
    last_status = 8'hF8;
    forever begin
      @(negedge clk);
      if (rst_n && status !== last_status) begin
        if (exp_q.size() == 0) chk(status, last_status, "scoreboard unexpected status change");
        else chk(status, exp_q.pop_front(), "scoreboard status sequence");
        last_status = status;
      end
    end
  end

  task automatic pulse_clr();
    expect_code(8'hF8);
    si_clr = 1'b1; tick(1); si_clr = 1'b0; tick(3);
  endtask

  task automatic pulse_sto();
    sto_set = 1'b1; tick(1); sto_set = 1'b0; tick(5);
  endtask

  task automatic bus_start();
    if (sda == 1'b0) begin
      scl = 1'b0; tick(6); sda = 1'b1; tick(6); scl = 1'b1; tick(6);
    end
    sda = 1'b0; tick(6);
  endtask

  task automatic bus_stop();
    if (sda == 1'b1) begin
      scl = 1'b0; tick(6); sda = 1'b0; tick(6); scl = 1'b1; tick(6);
    end
    sda = 1'b1; tick(6);
  endtask

  task automatic lose_arb();
    drv = 1'b1;
    scl = 1'b0; tick(6); sda = 1'b0; tick(6); scl = 1'b1; tick(6);
  endtask

  function automatic logic [7:0] lost_ref(input int k);
    logic [7:0] t [4] = '{8'h38, 8'h68, 8'h78, 8'hB0};
    return t[k];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3); rst_n = 1'b1; tick(2);
    // R1 reset state
    chk(status, 8'hF8, "R1 reset status");
    chk({7'd0, si}, 8'd0, "R1 reset flag");
    chk({7'd0, master}, 8'd0, "R1 reset master");
    chk({7'd0, busy}, 8'd0, "R1 reset busy");

    // R2 start on a free bus, R10 clear, R9 stop request
    expect_code(8'h08);
    sta = 1'b1; tick(4);
    chk({7'd0, master}, 8'd1, "R2 master after start");
    chk({7'd0, si}, 8'd1, "R2 flag after start");
    sta = 1'b0;
    pulse_clr();
    chk({7'd0, si}, 8'd0, "R10 flag cleared");
    sto_set = 1'b1; tick(1); sto_set = 1'b0;
    chk({7'd0, sto}, 8'd1, "R9 stop request pending");
    tick(5);
    chk({7'd0, master}, 8'd0, "R9 master released");
    chk({7'd0, busy}, 8'd0, "R9 bus freed");
    chk({7'd0, sto}, 8'd0, "R9 stop request served");

    // R4 + R5: lost arbitration with start held, automatic retry
    kind = 2'd1;
    expect_code(8'h08);
    sta = 1'b1; tick(4);
    expect_code(8'h68);
    lose_arb();
    chk({7'd0, master}, 8'd0, "R4 master dropped");
    chk({7'd0, si}, 8'd1, "R4 flag set");
    expect_code(8'h08);
    bus_stop();
    chk({7'd0, master}, 8'd1, "R5 retried master");
    sta = 1'b0;
    pulse_clr();
    pulse_sto();

    // R4 all remaining codes, start released first; R3 stop frees bus
    for (int k = 0; k < 4; k++) begin
      if (k == 1) continue;
      kind = k[1:0];
      expect_code(8'h08);
      sta = 1'b1; tick(4); sta = 1'b0; tick(2);
      expect_code(lost_ref(k));
      lose_arb();
      chk({7'd0, master}, 8'd0, "R4 master dropped");
      pulse_clr();
      bus_stop();
      chk({7'd0, busy}, 8'd0, "R3 stop frees bus");
    end

    // R6 foreign repeated start releases silently, retry after STOP
    expect_code(8'h08);
    sta = 1'b1; tick(4);
    pulse_clr();
    bus_start();
    chk({7'd0, master}, 8'd0, "R6 released");
    chk({7'd0, si}, 8'd0, "R6 flag untouched");
    chk(status, 8'hF8, "R6 status untouched");
    expect_code(8'h08);
    bus_stop();
    chk({7'd0, master}, 8'd1, "R6 retried master");
    sta = 1'b0;

    // R7 own repeated start, then R8 illegal STOP while master
    pulse_clr();
    rs_own = 1'b1;
    expect_code(8'h10);
    bus_start();
    chk({7'd0, master}, 8'd1, "R7 still master");
    chk({7'd0, si}, 8'd1, "R7 flag set");
    rs_own = 1'b0;
    pulse_clr();
    expect_code(8'h00);
    bus_stop();
    chk({7'd0, master}, 8'd0, "R8 master dropped on bus error");
    chk({7'd0, si}, 8'd1, "R8 flag on bus error");
    pulse_clr();

    // R8 bus error while addressed as slave clears pending stop
    sto_set = 1'b1; tick(1); sto_set = 1'b0; tick(2);
    chk({7'd0, sto}, 8'd1, "R8 stop pending before error");
    slv = 1'b1;
    expect_code(8'h00);
    bus_start();
    chk({7'd0, sto}, 8'd0, "R8 stop cleared by bus error");
    slv = 1'b0;
    pulse_clr();
    bus_stop();

    // R3 + R11 forced access on a stuck busy bus
    bus_start();
    chk({7'd0, busy}, 8'd1, "R3 start marks busy");
    expect_code(8'h08);
    sta = 1'b1; tick(10);
    chk({7'd0, master}, 8'd0, "R11 no takeover before limit");
    tick(30);
    chk({7'd0, master}, 8'd1, "R11 forced takeover");
    sta = 1'b0;
    pulse_clr();
    pulse_sto();
    chk({7'd0, busy}, 8'd0, "R9 bus freed after forced access");

    tick(5);
    chk(exp_q.size(), 8'd0, "scoreboard queue drained");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule